// File: doc/BRIEF.md
# Ancillary Packet Stripper with Format-Descriptor Capture

This block sits inline on a valid/ready video packet stream. The stream carries ordinary picture packets and ancillary-data packets, and each packet's first word says which kind it is. Picture packets go through in the same cycle with no added latency. Ancillary packets are absorbed and never reach the output. The upstream side is never held back while an ancillary packet is being absorbed.

While an ancillary packet is absorbed, the block walks through the ancillary items packed inside it. It compares each item's two identifier bytes against the active-format-description pair. When both match, it keeps the item's payload words. Once the whole item, including its trailing checksum word, has been received, the kept payload and a word count replace the contents of a small register bank. Downstream logic reads that bank through an address/data port.

Top module: `anc_strip_extract`

## Requirements
- R1: The packet kind is taken from bits [3:0] of the word that carries start-of-packet. The value 13 marks an ancillary packet. Every other value, including 0 for picture data, marks a packet that is forwarded.
- R2: Each word of a forwarded packet appears at the output in the same cycle with unchanged data, start and end flags: out_valid equals in_valid and in_ready equals out_ready.
- R3: No word of an ancillary packet, including its first word, ever appears at the output, and in_ready is 1 for every such word whatever the state of out_ready.
- R4: After the first word of an ancillary packet, items follow back to back. Each item is an identifier word, a secondary identifier word, a count word whose bits [7:0] give N, N payload words and one checksum word.
- R5: An item matches only when bits [7:0] of its identifier word equal 0x41 and bits [7:0] of its secondary identifier word equal 0x05. Matching only one of the two is not a match.
- R6: For a matching item, payload word k (k below 8) is readable at rd_addr = k, and afd_count becomes the smaller of N and 8. Payload words after the eighth are discarded.
- R7: The bank and afd_count change only in the cycle after a matching item's checksum word is accepted. A non-matching item, or a matching item cut short by the end of its packet, leaves them unchanged.
- R8: A non-matching item is skipped using its count word, so an item that follows it in the same packet is recognised correctly.
- R9: After reset, afd_count is 0, every bank entry reads 0, and with in_valid low in_ready follows out_ready.
- R10: When a match is committed, bank entries at addresses at or above the new count read 0. A matching item with N = 0 therefore clears the whole bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted |
| in_data | input | DATA_W | Upstream word |
| in_sop | input | 1 | Upstream start of packet |
| in_eop | input | 1 | Upstream end of packet |
| out_valid | output | 1 | Downstream word valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | DATA_W | Downstream word |
| out_sop | output | 1 | Downstream start of packet |
| out_eop | output | 1 | Downstream end of packet |
| rd_addr | input | IDX_W | Bank read address |
| rd_data | output | DATA_W | Bank entry at rd_addr |
| afd_count | output | CNT_W | Payload words held from the last match |

## Verification
A wrong pass/drop flag shows up at the ports in the very word it governs. Ancillary words leak to out_valid, or picture words vanish and in_ready stops tracking out_ready, so the bench checks every word on the cycle it is offered. A parser that loses its place inside an item, through a bad count or a wrong state step, only shows after the following checksum position: afd_count and the bank take wrong values, or keep stale ones, right after the packet ends. For that reason the bench reads back the whole bank after every ancillary packet. Back-to-back items, truncated items, near-miss identifiers and counts above 8 are aimed at those parser faults.

// File: rtl/anc_pkg.sv
// Package: shared states and constants for the ancillary stripper.
// Assumes: consumed by every module under anc_strip_extract.
package anc_pkg;
    typedef enum logic [2:0] {
        PS_DID  = 3'd0,
        PS_SDID = 3'd1,
        PS_DC   = 3'd2,
        PS_DATA = 3'd3,
        PS_CSUM = 3'd4
    } parse_st_t;
endpackage

// File: rtl/anc_stream_gate.sv
// Module: anc_stream_gate
// Classifies each packet at its first word. It forwards picture packets
// combinationally and swallows ancillary ones with ready held high.
// Assumes: in_sop marks the first word of every packet; the kind field sits
// in the low TYPE_W bits of that word.
module anc_stream_gate #(
    parameter int DATA_W   = 10,
    parameter int TYPE_W   = 4,
    parameter int ANC_TYPE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              anc_start,
    output logic              anc_word
);
    localparam logic [TYPE_W-1:0] ANC_CODE = TYPE_W'(ANC_TYPE);

    logic drop_q;
    logic cur_drop;
    logic fire;

    // Decide whether the current word belongs to an ancillary packet.
    always_comb begin
        cur_drop = in_sop ? (in_data[TYPE_W-1:0] == ANC_CODE) : drop_q;
        fire     = in_valid && in_ready;
    end

    // Forward or absorb the word and flag parser events.
    always_comb begin
        in_ready  = cur_drop || out_ready;
        out_valid = in_valid && !cur_drop;
        out_data  = in_data;
        out_sop   = in_sop;
        out_eop   = in_eop;
        anc_start = fire && cur_drop && in_sop;
        anc_word  = fire && cur_drop && !in_sop;
    end

    // Remember the packet kind for the words after the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (fire) begin
            drop_q <= cur_drop && !in_eop;
        end
    end
endmodule

// File: rtl/anc_item_parser.sv
// Module: anc_item_parser
// Walks the item sequence of an ancillary packet: identifier, secondary
// identifier, count, payload, checksum. It drives staging writes and a
// commit when a matching item completes.
// Assumes: anc_start and word_en are never high together.
module anc_item_parser #(
    parameter int          DATA_W    = 10,
    parameter int          MAX_WORDS = 8,
    parameter int          IDX_W     = 3,
    parameter int          CNT_W     = 4,
    parameter logic [7:0]  MATCH_DID  = 8'h41,
    parameter logic [7:0]  MATCH_SDID = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              anc_start,
    input  logic              word_en,
    input  logic [DATA_W-1:0] word,
    output logic              stage_clr,
    output logic              stage_we,
    output logic [IDX_W-1:0]  stage_idx,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_cnt
);
    import anc_pkg::*;

    localparam logic [7:0] MAX8 = 8'(MAX_WORDS);

    parse_st_t  st_q;
    logic       did_hit_q;
    logic       match_q;
    logic [7:0] dc_q;
    logic [7:0] pos_q;

    // Step through the item fields on every absorbed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= PS_DID;
            did_hit_q <= 1'b0;
            match_q   <= 1'b0;
            dc_q      <= 8'd0;
            pos_q     <= 8'd0;
        end else if (anc_start) begin
            st_q <= PS_DID;
        end else if (word_en) begin
            case (st_q)
                PS_DID: begin
                    did_hit_q <= (word[7:0] == MATCH_DID);
                    st_q      <= PS_SDID;
                end
                PS_SDID: begin
                    match_q <= did_hit_q && (word[7:0] == MATCH_SDID);
                    st_q    <= PS_DC;
                end
                PS_DC: begin
                    dc_q  <= word[7:0];
                    pos_q <= 8'd0;
                    st_q  <= (word[7:0] == 8'd0) ? PS_CSUM : PS_DATA;
                end
                PS_DATA: begin
                    pos_q <= pos_q + 8'd1;
                    if (pos_q == dc_q - 8'd1) begin
                        st_q <= PS_CSUM;
                    end
                end
                default: begin
                    st_q <= PS_DID;
                end
            endcase
        end
    end

    // Derive staging and commit strobes from the current field.
    always_comb begin
        stage_clr  = word_en && (st_q == PS_DC);
        stage_we   = word_en && (st_q == PS_DATA) && (pos_q < MAX8);
        stage_idx  = pos_q[IDX_W-1:0];
        commit     = word_en && (st_q == PS_CSUM) && match_q;
        commit_cnt = (dc_q > MAX8) ? CNT_W'(MAX_WORDS) : dc_q[CNT_W-1:0];
    end
endmodule

// File: rtl/anc_reg_bank.sv
// Module: anc_reg_bank
// Staging row filled during an item plus a visible row that takes a copy
// of the staging row on commit. It also holds the visible word count.
// Assumes: stage_clr arrives before the first stage_we of each item.
module anc_reg_bank #(
    parameter int DATA_W    = 10,
    parameter int MAX_WORDS = 8,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_clr,
    input  logic              stage_we,
    input  logic [IDX_W-1:0]  stage_idx,
    input  logic [DATA_W-1:0] stage_data,
    input  logic              commit,
    input  logic [CNT_W-1:0]  commit_cnt,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  afd_count
);
    logic [DATA_W-1:0] stage_q [MAX_WORDS];
    logic [DATA_W-1:0] bank_q  [MAX_WORDS];

    for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : g_entry
        // Collect one payload word of the item being parsed.
        always_ff @(posedge clk) begin
            if (!rst_n || stage_clr) begin
                stage_q[gi] <= '0;
            end else if (stage_we && stage_idx == IDX_W'(gi)) begin
                stage_q[gi] <= stage_data;
            end
        end

        // Publish the staged word once its item is complete.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[gi] <= '0;
            end else if (commit) begin
                bank_q[gi] <= stage_q[gi];
            end
        end
    end

    // Publish the word count together with the payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            afd_count <= '0;
        end else if (commit) begin
            afd_count <= commit_cnt;
        end
    end

    // Read port over the visible row.
    always_comb begin
        rd_data = (32'(rd_addr) < MAX_WORDS) ? bank_q[rd_addr] : '0;
    end
endmodule

// File: rtl/anc_strip_extract.sv
// Module: anc_strip_extract (top)
// Removes ancillary packets from a valid/ready packet stream and captures
// the payload of active-format-description items into a readable bank.
// Assumes: well-formed start/end framing on the input stream.
module anc_strip_extract #(
    parameter int         DATA_W     = 10,
    parameter int         TYPE_W     = 4,
    parameter int         ANC_TYPE   = 13,
    parameter int         MAX_WORDS  = 8,
    parameter logic [7:0] MATCH_DID  = 8'h41,
    parameter logic [7:0] MATCH_SDID = 8'h05,
    localparam int        IDX_W      = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int        CNT_W      = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  afd_count
);
    logic              anc_start;
    logic              anc_word;
    logic              stage_clr;
    logic              stage_we;
    logic [IDX_W-1:0]  stage_idx;
    logic              commit;
    logic [CNT_W-1:0]  commit_cnt;

    anc_stream_gate #(
        .DATA_W(DATA_W), .TYPE_W(TYPE_W), .ANC_TYPE(ANC_TYPE)
    ) gate_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .anc_start(anc_start), .anc_word(anc_word)
    );

    anc_item_parser #(
        .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .MATCH_DID(MATCH_DID), .MATCH_SDID(MATCH_SDID)
    ) parser_i (
        .clk(clk), .rst_n(rst_n),
        .anc_start(anc_start), .word_en(anc_word), .word(in_data),
        .stage_clr(stage_clr), .stage_we(stage_we), .stage_idx(stage_idx),
        .commit(commit), .commit_cnt(commit_cnt)
    );

    anc_reg_bank #(
        .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .stage_clr(stage_clr), .stage_we(stage_we), .stage_idx(stage_idx),
        .stage_data(in_data), .commit(commit), .commit_cnt(commit_cnt),
        .rd_addr(rd_addr), .rd_data(rd_data), .afd_count(afd_count)
    );
endmodule

// File: rtl/anc_strip_checker.sv
// Module: anc_strip_checker
// Port-level properties of anc_strip_extract, attached with bind.
// Assumes: the same parameter values as the bound instance.
module anc_strip_checker #(
    parameter int DATA_W    = 10,
    parameter int TYPE_W    = 4,
    parameter int ANC_TYPE  = 13,
    parameter int MAX_WORDS = 8,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              in_sop,
    input logic              in_eop,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic [IDX_W-1:0]  rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  afd_count
);
    localparam logic [TYPE_W-1:0] ANC_CODE = TYPE_W'(ANC_TYPE);

    // R3: an ancillary header is hidden and accepted
    p_anc_hdr_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_data[TYPE_W-1:0] == ANC_CODE)
        |-> (!out_valid && in_ready));

    // R2: a non-ancillary header is forwarded unchanged
    p_hdr_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_data[TYPE_W-1:0] != ANC_CODE)
        |-> (out_valid && out_sop && out_data == in_data && in_ready == out_ready));

    // R6: the count never exceeds the bank depth
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        afd_count <= CNT_W'(MAX_WORDS));

    // R7: without an accepted word the count cannot move
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(afd_count));

    // R1: output never carries a word the input did not offer
    p_no_phantom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);
endmodule

bind anc_strip_extract anc_strip_checker #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .ANC_TYPE(ANC_TYPE),
    .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/anc_strip_extract_tb_top.sv
// Bench for anc_strip_extract: directed corner cases then seeded random
// packets, checked word by word and by bank read-back after each packet.
module anc_strip_extract_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [9:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [9:0] out_data;
    logic       out_sop;
    logic       out_eop;
    logic [2:0] rd_addr = '0;
    logic [9:0] rd_data;
    logic [3:0] afd_count;

    int checks = 0;
    int fails  = 0;
    bit cur_anc = 1'b0;
    bit stall_mode = 1'b0;
    logic [9:0] pkt [0:63];
    int plen = 0;
    logic [9:0] exp_bank [0:7];
    int exp_cnt = 0;

    always #4 clk = ~clk;

    anc_strip_extract dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .rd_addr(rd_addr), .rd_data(rd_data), .afd_count(afd_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] w);
        pkt[plen] = w;
        plen++;
    endtask

    task automatic add_item(input logic [7:0] did, input logic [7:0] sdid, input int dc);
        push({2'($urandom), did});
        push({2'($urandom), sdid});
        push({2'($urandom), 8'(dc)});
        for (int k = 0; k < dc; k++) push(10'($urandom));
        push(10'($urandom));
    endtask

    task automatic send_word(input logic [9:0] w, input bit sop, input bit eop);
        bit acc;
        bit drop;
        drop = sop ? (w[3:0] == 4'd13) : cur_anc;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = w; in_sop = sop; in_eop = eop;
            out_ready = stall_mode ? 1'b0 : ($urandom % 4 != 0);
            #1;
            if (drop) begin
                chk(in_ready === 1'b1, "R3 ready while absorbing", int'(in_ready), 1);
                chk(out_valid === 1'b0, "R3 ancillary word hidden", int'(out_valid), 0);
            end else begin
                chk(out_valid === 1'b1 && out_data === w && out_sop === sop && out_eop === eop,
                    "R2 forwarded word", int'({out_valid, out_sop, out_eop, out_data}),
                    int'({1'b1, sop, eop, w}));
                chk(in_ready === out_ready, "R2 ready follows out_ready",
                    int'(in_ready), int'(out_ready));
            end
            acc = in_ready;
            @(posedge clk);
        end
        cur_anc = drop;
    endtask

    // Bench model of the bank after one ancillary packet held in pkt[].
    task automatic model_anc();
        int idx;
        int dc;
        idx = 1;
        while (idx + 2 < plen) begin
            dc = int'(pkt[idx + 2][7:0]);
            if (idx + 3 + dc < plen && pkt[idx][7:0] == 8'h41 && pkt[idx + 1][7:0] == 8'h05) begin
                for (int i = 0; i < 8; i++)
                    exp_bank[i] = (i < dc) ? pkt[idx + 3 + i] : 10'd0;
                exp_cnt = (dc > 8) ? 8 : dc;
            end
            idx = idx + 4 + dc;
        end
    endtask

    task automatic check_bank(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(int'(afd_count) == exp_cnt, {req, " count"}, int'(afd_count), exp_cnt);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #1;
            chk(rd_data === exp_bank[i], {req, " bank entry"}, int'(rd_data), int'(exp_bank[i]));
        end
    endtask

    task automatic send_pkt(input string req);
        bit is_anc;
        is_anc = (pkt[0][3:0] == 4'd13);
        for (int w = 0; w < plen; w++) begin
            send_word(pkt[w], w == 0, w == plen - 1);
            if (!stall_mode && $urandom % 5 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        if (is_anc) model_anc();
        check_bank(req);
    endtask

    task automatic new_pkt(input logic [3:0] kind);
        plen = 0;
        push({6'($urandom), kind});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) exp_bank[i] = 10'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        out_ready = 1'b0;
        #1;
        chk(in_ready === 1'b0, "R9 idle ready low", int'(in_ready), 0);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        chk(in_ready === 1'b1, "R9 idle ready high", int'(in_ready), 1);
        check_bank("R9 reset");

        // R1 R2: picture packet type 0
        new_pkt(4'd0);
        for (int i = 0; i < 5; i++) push(10'($urandom));
        send_pkt("R1 picture");

        // R1: other kind code also forwarded
        new_pkt(4'd5);
        for (int i = 0; i < 3; i++) push(10'($urandom));
        send_pkt("R1 kind5");

        // R4 R5 R6: single matching item
        new_pkt(4'd13);
        add_item(8'h41, 8'h05, 3);
        send_pkt("R6 match3");

        // R5: identifier match with wrong secondary id leaves bank
        new_pkt(4'd13);
        add_item(8'h41, 8'h06, 2);
        add_item(8'h40, 8'h05, 2);
        send_pkt("R5 near miss");

        // R8 R6: skip then match with count above depth
        new_pkt(4'd13);
        add_item(8'h12, 8'h34, 2);
        add_item(8'h41, 8'h05, 10);
        send_pkt("R8 skip then clip");

        // R7: matching item cut before checksum
        new_pkt(4'd13);
        add_item(8'h41, 8'h05, 4);
        plen = plen - 1;
        send_pkt("R7 truncated");

        // R10: zero-length match clears the bank
        new_pkt(4'd13);
        add_item(8'h41, 8'h05, 0);
        send_pkt("R10 empty match");

        // R3: stalled downstream while absorbing
        stall_mode = 1'b1;
        new_pkt(4'd13);
        add_item(8'h41, 8'h05, 5);
        send_pkt("R3 stalled absorb");
        stall_mode = 1'b0;

        // R10: shorter match after longer one zeroes upper entries
        new_pkt(4'd13);
        add_item(8'h41, 8'h05, 2);
        send_pkt("R10 shrink");

        // Random mix
        for (int n = 0; n < 150; n++) begin
            int sel;
            sel = $urandom % 3;
            if (sel == 0) begin
                new_pkt(4'd13);
                for (int it = 0; it < 1 + int'($urandom % 3); it++) begin
                    if ($urandom % 2 == 0) add_item(8'h41, 8'h05, $urandom % 12);
                    else add_item(8'($urandom), (($urandom % 2) == 0) ? 8'h05 : 8'($urandom), $urandom % 6);
                end
                if ($urandom % 4 == 0 && plen > 2) plen = plen - 1 - int'($urandom % 2);
                send_pkt("R7 random ancillary");
            end else begin
                new_pkt((sel == 1) ? 4'd0 : 4'(1 + $urandom % 12));
                for (int i = 0; i < int'($urandom % 8); i++) push(10'($urandom));
                send_pkt("R2 random forward");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule